// File: doc/BRIEF.md
# Serial Boot Image Loader

This block keeps a host processor in reset after power-up and after every press of the reset button. While the processor is held, the block receives a binary image of fixed length over an asynchronous serial line. It stores each received byte at the next memory address, counting up from zero.

When the final byte has been written, the block releases the processor's reset, so execution starts at address zero from the freshly loaded image. Nothing else reaches memory until the next reset.

The receiver oversamples the line at sixteen times the bit rate. The divisor that produces this rate is derived from the clock frequency and baud parameters. A byte with a bad parity bit or a low stop bit still occupies its slot in the image, but it raises a flag that stays set until the next reset.

Top module: `serial_boot_loader`

## Requirements
- R1: While `rst_ni` is low, `cpu_rst_no` is 0, `mem_we_o` is 0 and `err_o` is 0. Loading restarts every time `rst_ni` is released.
- R2: Each frame is one low start bit, then 8 data bits with the least significant bit first, then one parity bit, then one high stop bit. Every bit lasts `16*DIV` clocks, where `DIV = round(CLK_HZ/(16*BAUD))` and is at least 1.
- R3: Each received byte produces one `mem_we_o` pulse of exactly one cycle. The address is the byte's arrival index, counting 0, 1, ... up to `IMG_BYTES-1`, and `mem_data_o` carries the byte.
- R4: `cpu_rst_no` stays 0 while bytes are being stored. It goes to 1 exactly one clock after the write strobe of byte number `IMG_BYTES-1`.
- R5: After release, further serial frames produce no memory writes, and `cpu_rst_no` stays 1 until `rst_ni` is asserted.
- R6: The parity is odd: the data bits and the parity bit together hold an odd number of ones. A byte that breaks this sets `err_o`, which then stays set. The byte is still written and counted.
- R7: A frame whose stop bit samples low sets the sticky `err_o`. The byte is still written and counted.
- R8: A low pulse on `rx_i` counts as a start bit only if the line is still low at the middle of the start bit. A shorter pulse produces no write.
- R9: Asserting `rst_ni` part way through a load clears `err_o`. The next load starts again at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset (power-up or button) |
| rx_i | input | 1 | Serial receive line, idle high |
| mem_addr_o | output | AW | Write address, AW = clog2(IMG_BYTES) |
| mem_data_o | output | 8 | Write data |
| mem_we_o | output | 1 | One-cycle write strobe |
| cpu_rst_no | output | 1 | Active-low reset to the host processor |
| err_o | output | 1 | Sticky parity or framing error seen during the load |

## Verification
The bench sweeps all 256 byte values through consecutive loads. This catches a receiver with the wrong bit order or the wrong parity sense, which would store wrong data or flag clean bytes.

The bench also checks that the release comes exactly one clock after the last write. A sequencer that counts one byte too many, or one too few, would release early, release late, or never release.

Injected parity and stop-bit errors must set the flag and still advance the address. A design that drops bad bytes would shift the rest of the image down by one slot.

A short glitch, a byte sent after release, and a reset in the middle of a load are also exercised. A design without the mid-bit start check would store a spurious byte. A design that keeps its count across reset would start the next image at the wrong address.

// File: rtl/boot_loader_pkg.sv
package boot_loader_pkg;
  typedef enum logic [2:0] {
    RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP
  } rx_state_e;

  typedef struct packed {
    logic [7:0] data;
    logic       par_err;
    logic       frm_err;
  } rx_byte_t;
endpackage

// File: rtl/blr_baud_tick.sv
module blr_baud_tick #(
  parameter int DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  generate
    if (DIV <= 1) begin : g_every
      assign tick_o = 1'b1;
    end else begin : g_div
      localparam int CW = $clog2(DIV);
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else if (cnt_q == CW'(DIV - 1)) cnt_q <= '0;
        else cnt_q <= cnt_q + 1'b1;
      end
      assign tick_o = (cnt_q == CW'(DIV - 1));
    end
  endgenerate
endmodule

// File: rtl/blr_uart_rx.sv
module blr_uart_rx
  import boot_loader_pkg::*;
#(
  parameter int OS = 16
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     tick_i,
  input  logic     rx_i,
  output logic     valid_o,
  output rx_byte_t byte_o
);
  localparam int OSW = $clog2(OS);
  localparam logic [OSW-1:0] MID  = OSW'(OS / 2 - 1);
  localparam logic [OSW-1:0] LAST = OSW'(OS - 1);

  rx_state_e      state_q;
  logic [1:0]     sync_q;
  logic           prev_q;
  logic [OSW-1:0] os_q;
  logic [2:0]     bit_q;
  logic [7:0]     sh_q;
  logic           par_q;
  logic           valid_q;
  rx_byte_t       byte_q;
  logic           rx_s;

  assign rx_s = sync_q[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RX_IDLE;
      sync_q  <= 2'b11;
      prev_q  <= 1'b1;
      os_q    <= '0;
      bit_q   <= '0;
      sh_q    <= '0;
      par_q   <= 1'b0;
      valid_q <= 1'b0;
      byte_q  <= '0;
    end else begin
      sync_q  <= {sync_q[0], rx_i};
      prev_q  <= rx_s;
      valid_q <= 1'b0;
      unique case (state_q)
        RX_IDLE: if (prev_q && !rx_s) begin  // falling edge only
          state_q <= RX_START;
          os_q    <= '0;
        end
        RX_START: if (tick_i) begin
          if (os_q == MID) begin
            os_q    <= '0;
            bit_q   <= '0;
            state_q <= rx_s ? RX_IDLE : RX_DATA;
          end else os_q <= os_q + 1'b1;
        end
        RX_DATA: if (tick_i) begin
          if (os_q == LAST) begin
            os_q <= '0;
            sh_q <= {rx_s, sh_q[7:1]};
            if (bit_q == 3'd7) state_q <= RX_PAR;
            else bit_q <= bit_q + 1'b1;
          end else os_q <= os_q + 1'b1;
        end
        RX_PAR: if (tick_i) begin
          if (os_q == LAST) begin
            os_q    <= '0;
            par_q   <= rx_s;
            state_q <= RX_STOP;
          end else os_q <= os_q + 1'b1;
        end
        RX_STOP: if (tick_i) begin
          if (os_q == LAST) begin
            os_q           <= '0;
            valid_q        <= 1'b1;
            byte_q.data    <= sh_q;
            byte_q.par_err <= ~(^{sh_q, par_q});
            byte_q.frm_err <= ~rx_s;
            state_q        <= RX_IDLE;
          end else os_q <= os_q + 1'b1;
        end
        default: state_q <= RX_IDLE;
      endcase
    end
  end

  assign valid_o = valid_q;
  assign byte_o  = byte_q;
endmodule

// File: rtl/blr_boot_seq.sv
module blr_boot_seq
  import boot_loader_pkg::*;
#(
  parameter int IMG_BYTES = 256,
  localparam int AW = (IMG_BYTES > 1) ? $clog2(IMG_BYTES) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  rx_byte_t      byte_i,
  output logic [AW-1:0] addr_o,
  output logic [7:0]    data_o,
  output logic          we_o,
  output logic          cpu_rst_no,
  output logic          err_o
);
  logic          loading_q;
  logic [AW-1:0] cnt_q;
  logic [AW-1:0] addr_q;
  logic [7:0]    data_q;
  logic          we_q;
  logic          rel_q;
  logic          err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      loading_q <= 1'b1;
      cnt_q     <= '0;
      addr_q    <= '0;
      data_q    <= '0;
      we_q      <= 1'b0;
      rel_q     <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      we_q  <= 1'b0;
      rel_q <= ~loading_q;  // release one cycle after the last strobe
      if (valid_i && loading_q) begin
        we_q   <= 1'b1;
        addr_q <= cnt_q;
        data_q <= byte_i.data;
        cnt_q  <= cnt_q + 1'b1;
        err_q  <= err_q | byte_i.par_err | byte_i.frm_err;
        if (cnt_q == AW'(IMG_BYTES - 1)) loading_q <= 1'b0;
      end
    end
  end

  assign addr_o     = addr_q;
  assign data_o     = data_q;
  assign we_o       = we_q;
  assign cpu_rst_no = rel_q;
  assign err_o      = err_q;
endmodule

// File: rtl/serial_boot_loader.sv
module serial_boot_loader
  import boot_loader_pkg::*;
#(
  parameter int CLK_HZ    = 50_000_000,
  parameter int BAUD      = 57_600,
  parameter int OS        = 16,
  parameter int IMG_BYTES = 256,
  localparam int AW       = (IMG_BYTES > 1) ? $clog2(IMG_BYTES) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rx_i,
  output logic [AW-1:0] mem_addr_o,
  output logic [7:0]    mem_data_o,
  output logic          mem_we_o,
  output logic          cpu_rst_no,
  output logic          err_o
);
  localparam int DIV_RAW = (CLK_HZ + (BAUD * OS) / 2) / (BAUD * OS);
  localparam int DIV     = (DIV_RAW < 1) ? 1 : DIV_RAW;

  logic     tick;
  logic     rx_valid;
  rx_byte_t rx_byte;

  blr_baud_tick #(.DIV(DIV)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick)
  );

  blr_uart_rx #(.OS(OS)) u_rx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick),
    .rx_i   (rx_i),
    .valid_o(rx_valid),
    .byte_o (rx_byte)
  );

  blr_boot_seq #(.IMG_BYTES(IMG_BYTES)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (rx_valid),
    .byte_i    (rx_byte),
    .addr_o    (mem_addr_o),
    .data_o    (mem_data_o),
    .we_o      (mem_we_o),
    .cpu_rst_no(cpu_rst_no),
    .err_o     (err_o)
  );
endmodule

// File: rtl/serial_boot_loader_chk.sv
module serial_boot_loader_chk #(
  parameter int IMG_BYTES = 256,
  localparam int AW = (IMG_BYTES > 1) ? $clog2(IMG_BYTES) : 1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          mem_we_o,
  input logic [AW-1:0] mem_addr_o,
  input logic          cpu_rst_no,
  input logic          err_o
);
  logic [AW:0] wr_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wr_cnt_q <= '0;
    else if (mem_we_o) wr_cnt_q <= wr_cnt_q + 1'b1;
  end

  p_addr_order_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (mem_addr_o == wr_cnt_q[AW-1:0]));
  p_we_single_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> !mem_we_o);
  p_hold_during_load_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> !cpu_rst_no);
  p_release_after_last_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cpu_rst_no) |-> ($past(mem_we_o) && $past(mem_addr_o) == AW'(IMG_BYTES - 1)));
  p_stay_released_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_rst_no |=> cpu_rst_no);
  p_err_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);
  p_count_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_cnt_q <= (AW + 1)'(IMG_BYTES));
endmodule

bind serial_boot_loader serial_boot_loader_chk #(.IMG_BYTES(IMG_BYTES)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .mem_we_o  (mem_we_o),
  .mem_addr_o(mem_addr_o),
  .cpu_rst_no(cpu_rst_no),
  .err_o     (err_o)
);

// File: tb/serial_boot_loader_bench.sv
`timescale 1ns/1ps
module serial_boot_loader_bench;
  localparam int CLK_HZ = 1_843_200;
  localparam int BAUD   = 57_600;
  localparam int IMG    = 32;
  localparam int AW     = $clog2(IMG);
  localparam int BITC   = 16 * 2;  // DIV = 2

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx = 1'b1;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_data;
  logic mem_we, cpu_rst_n, err;

  always #2.5 clk = ~clk;

  serial_boot_loader #(.CLK_HZ(CLK_HZ), .BAUD(BAUD), .IMG_BYTES(IMG)) u_serial_boot_loader (
    .clk_i(clk), .rst_ni(rst_n), .rx_i(rx),
    .mem_addr_o(mem_addr), .mem_data_o(mem_data), .mem_we_o(mem_we),
    .cpu_rst_no(cpu_rst_n), .err_o(err)
  );

  int n_chk = 0, n_bad = 0;
  int cyc = 0, wcnt = 0, last_we = -1, rel_cyc = -1, hold_viol = 0;
  logic prev_rel = 1'b0;
  logic [AW-1:0] cap_addr [IMG];
  logic [7:0]    cap_data [IMG];

  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      wcnt = 0; prev_rel = 1'b0; rel_cyc = -1; last_we = -1; hold_viol = 0;
    end else begin
      if (mem_we) begin
        if (wcnt < IMG) begin cap_addr[wcnt] = mem_addr; cap_data[wcnt] = mem_data; end
        if (cpu_rst_n) hold_viol++;
        wcnt++;
        last_we = cyc;
      end
      if (cpu_rst_n && !prev_rel) rel_cyc = cyc;
      prev_rel = cpu_rst_n;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_bits(input int n);
    repeat (n * BITC) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] d, input bit bad_par, input bit bad_stop);
    rx = 1'b0; wait_bits(1);
    for (int i = 0; i < 8; i++) begin rx = d[i]; wait_bits(1); end
    rx = (~^d) ^ bad_par; wait_bits(1);
    rx = ~bad_stop; wait_bits(1);
    rx = 1'b1; wait_bits(1);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(cpu_rst_n == 1'b0, "R1 cpu reset held", cpu_rst_n, 0);
    chk(mem_we == 1'b0, "R1 no write in reset", mem_we, 0);
    chk(err == 1'b0, "R1 err clear in reset", err, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (190_000) @(posedge clk);
    n_bad++;
    $display("FAIL R4 watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int bad_cnt;
    // 8 loads of 32 bytes sweep every byte value
    for (int b = 0; b < 8; b++) begin
      bit exp_err;
      do_reset();
      if (b == 1) begin  // R8: glitch well under half a bit
        rx = 1'b0; repeat (6) @(negedge clk); rx = 1'b1;
        wait_bits(2);
        chk(wcnt == 0, "R8 glitch ignored", wcnt, 0);
      end
      exp_err = 1'b0;
      for (int i = 0; i < IMG; i++) begin
        bit bp, bs;
        bp = (b == 2 && i == 5);
        bs = (b == 5 && i == 10);
        exp_err |= bp | bs;
        if (i == IMG - 1)
          chk(cpu_rst_n == 1'b0, "R4 held before last byte", cpu_rst_n, 0);
        send_byte(8'((b * IMG + i) * 37 + 11), bp, bs);
      end
      repeat (40) @(negedge clk);
      chk(wcnt == IMG, "R3 write count", wcnt, IMG);
      bad_cnt = 0;
      for (int i = 0; i < IMG; i++) begin
        if (cap_addr[i] != AW'(i) || cap_data[i] != 8'((b * IMG + i) * 37 + 11)) bad_cnt++;
      end
      chk(bad_cnt == 0, "R2 R3 data and address order", bad_cnt, 0);
      chk(cpu_rst_n == 1'b1, "R4 released", cpu_rst_n, 1);
      chk(rel_cyc == last_we + 1, "R4 release one cycle after last write", rel_cyc - last_we, 1);
      chk(hold_viol == 0, "R4 no write after release", hold_viol, 0);
      if (b == 2) chk(err == exp_err, "R6 parity error sticky", err, exp_err);
      else if (b == 5) chk(err == exp_err, "R7 framing error sticky", err, exp_err);
      else chk(err == 1'b0, "R6 no error on clean load", err, 0);
      if (b == 0) begin
        send_byte(8'h5A, 1'b0, 1'b0);
        repeat (40) @(negedge clk);
        chk(wcnt == IMG, "R5 no write after release", wcnt, IMG);
        chk(cpu_rst_n == 1'b1, "R5 stays released", cpu_rst_n, 1);
      end
    end
    // R9: reset part way through a load
    do_reset();
    for (int i = 0; i < 5; i++) send_byte(8'hC3 ^ 8'(i), i == 2, 1'b0);
    repeat (40) @(negedge clk);
    chk(wcnt == 5, "R9 partial count", wcnt, 5);
    chk(err == 1'b1, "R6 partial load error", err, 1);
    do_reset();
    chk(err == 1'b0, "R9 err cleared by reset", err, 0);
    for (int i = 0; i < IMG; i++) send_byte(8'hA5 ^ 8'(i), 1'b0, 1'b0);
    repeat (40) @(negedge clk);
    chk(wcnt == IMG, "R9 full reload count", wcnt, IMG);
    chk(cap_addr[0] == '0, "R9 restart at address 0", cap_addr[0], 0);
    chk(cap_data[IMG-1] == (8'hA5 ^ 8'(IMG - 1)), "R9 last byte", cap_data[IMG-1], 8'hA5 ^ 8'(IMG - 1));
    chk(cpu_rst_n == 1'b1, "R9 released after reload", cpu_rst_n, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule